// File: doc/BRIEF.md
# Receive Word Host Buffer

This block sits between a receive decoder and an 8-bit microprocessor bus. The decoder hands over each 28-bit word with a one-cycle valid strobe. The block stores the word, raises a data-available flag, and raises an interrupt request that the host can mask. The host then fetches the word as four byte reads at byte addresses 0 to 3. The most significant byte comes first, and its upper nibble is padded with zeros.

Reading the final byte, which holds the least-significant bits, releases the buffer. A word that lands before the host has released the previous one overwrites it, and a sticky overrun flag records the loss. The final read clears that flag as well. Read data is a combinational function of the byte address, so the host samples it in the same cycle as its strobe.

Top module: `rx_word_host_buf`

## Requirements
- R1: After reset, `avail_o`, `ovr_o` and `irq_o` are 0, and `rdata_o` reads 0 at every address.
- R2: In the cycle after `word_vld_i` is high, `avail_o` is 1 and the new word is readable.
- R3: `rdata_o` follows `addr_i` in the same cycle. Address 0 returns {4'b0000, word[27:24]}, address 1 returns word[23:16], address 2 returns word[15:8] and address 3 returns word[7:0].
- R4: A read strobe at address 0, 1 or 2 leaves `avail_o` and `ovr_o` unchanged.
- R5: A read strobe at address 3 with no new word in the same cycle clears `avail_o` and `ovr_o` in the next cycle.
- R6: `irq_o` is high exactly when `avail_o` and `irq_en_i` are both 1. Setting `irq_en_i` while a word is pending raises `irq_o` in the same cycle.
- R7: A new word that arrives while `avail_o` is 1 replaces the stored word and sets `ovr_o` in the next cycle.
- R8: When a new word and a read strobe at address 3 fall in the same cycle, the read returns the old low byte. In the next cycle the new word is stored, `avail_o` stays 1 and `ovr_o` is 0.
- R9: When `addr_i` is 3 and `rd_i` is low, `avail_o` is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 28 | Decoded word from the decoder |
| word_vld_i | input | 1 | Strobe that loads `word_i` |
| rd_i | input | 1 | Host read strobe |
| addr_i | input | 2 | Host byte address |
| irq_en_i | input | 1 | Interrupt enable (mask) |
| rdata_o | output | 8 | Byte selected by `addr_i` |
| avail_o | output | 1 | A word is waiting to be read |
| ovr_o | output | 1 | Sticky flag: an unread word was overwritten |
| irq_o | output | 1 | Interrupt request |

## Verification
Words with distinct values in every nibble test whether the byte order and the zero pad of byte 0 are right. An all-ones word shows whether any pad bit leaks into the top nibble. Reads at addresses 0 to 2, and an idle address 3 without a strobe, tell a correct release apart from early clearing. Back-to-back words, and a word that coincides with the final read, tell overwrite with overrun apart from the priority case in which the new word survives and no overrun is flagged. Toggling the mask with data pending separates immediate unmasking from edge-triggered behaviour.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  function automatic int unsigned n_bytes(int unsigned word_w, int unsigned byte_w);
    return (word_w + byte_w - 1) / byte_w;
  endfunction
endpackage

// File: rtl/rxwb_store.sv
module rxwb_store #(
  parameter int unsigned WORD_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              vld_i,
  input  logic              clr_i,
  output logic [WORD_W-1:0] word_o,
  output logic              avail_o,
  output logic              ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      avail_o <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      if (vld_i) word_o <= word_i;
      // new word wins over release
      if (vld_i)      avail_o <= 1'b1;
      else if (clr_i) avail_o <= 1'b0;
      // release consumes the old word, so a coincident arrival is no overrun
      if (clr_i)                 ovr_o <= 1'b0;
      else if (vld_i && avail_o) ovr_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rxwb_rd_mux.sv
module rxwb_rd_mux #(
  parameter int unsigned WORD_W  = 28,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned N_BYTES = 4,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = N_BYTES * BYTE_W;

  logic [PAD_W-1:0]  padded;
  logic [BYTE_W-1:0] slice [N_BYTES];

  assign padded = PAD_W'(word_i);

  // byte 0 is the most significant slice
  for (genvar k = 0; k < N_BYTES; k++) begin : g_slice
    assign slice[k] = padded[(N_BYTES-1-k)*BYTE_W +: BYTE_W];
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_BYTES; k++)
      if (addr_i == ADDR_W'(k)) rdata_o = slice[k];
  end
endmodule

// File: rtl/rxwb_irq.sv
module rxwb_irq (
  input  logic avail_i,
  input  logic en_i,
  output logic irq_o
);
  assign irq_o = avail_i & en_i;
endmodule

// File: rtl/rx_word_host_buf.sv
module rx_word_host_buf
  import rxwb_pkg::*;
#(
  parameter int unsigned WORD_W = 28,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned N_BYTES = n_bytes(WORD_W, BYTE_W),
  localparam int unsigned ADDR_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              irq_en_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              avail_o,
  output logic              ovr_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_BYTES - 1);

  logic [WORD_W-1:0] word_q;
  logic              last_rd;

  assign last_rd = rd_i && (addr_i == LAST_ADDR);

  rxwb_store #(.WORD_W(WORD_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .word_i  (word_i),
    .vld_i   (word_vld_i),
    .clr_i   (last_rd),
    .word_o  (word_q),
    .avail_o (avail_o),
    .ovr_o   (ovr_o)
  );

  rxwb_rd_mux #(
    .WORD_W (WORD_W),
    .BYTE_W (BYTE_W),
    .N_BYTES(N_BYTES),
    .ADDR_W (ADDR_W)
  ) u_mux (
    .word_i (word_q),
    .addr_i (addr_i),
    .rdata_o(rdata_o)
  );

  rxwb_irq u_irq (
    .avail_i(avail_o),
    .en_i   (irq_en_i),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/rxwb_chk.sv
module rxwb_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_vld_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BYTE_W-1:0] rdata_o,
  input logic              avail_o,
  input logic              ovr_o,
  input logic              irq_o
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic fin;
  assign fin = rd_i && (addr_i == LAST);

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_i |=> avail_o);

  assert_pad_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0) |-> (rdata_o[BYTE_W-1:4] == '0));

  // R4 and R9: without release or arrival the flags hold
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_vld_i && !fin) |=> ($stable(avail_o) && $stable(ovr_o)));

  assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !word_vld_i) |=> (!avail_o && !ovr_o));

  assert_irq_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avail_o |-> !irq_o);

  assert_overrun_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && avail_o && !fin) |=> ovr_o);

  assert_priority_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && fin) |=> (avail_o && !ovr_o));
endmodule

bind rx_word_host_buf rxwb_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .word_vld_i(word_vld_i),
  .rd_i      (rd_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .avail_o   (avail_o),
  .ovr_o     (ovr_o),
  .irq_o     (irq_o)
);

// File: tb/rx_word_host_buf_tb.sv
module rx_word_host_buf_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [27:0] word_i = '0;
  logic        word_vld_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        irq_en_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        avail_o, ovr_o, irq_o;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk_i = ~clk_i;

  rx_word_host_buf u_dut (
    .clk_i, .rst_ni, .word_i, .word_vld_i, .rd_i, .addr_i,
    .irq_en_i, .rdata_o, .avail_o, .ovr_o, .irq_o
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(logic [27:0] w, int k);
    case (k)
      0:       return {4'h0, w[27:24]};
      1:       return w[23:16];
      2:       return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic send(logic [27:0] w);
    word_i = w; word_vld_i = 1'b1;
    tick();
    word_vld_i = 1'b0;
  endtask

  // driver: push the expected byte, strobe one read
  task automatic read_byte(logic [27:0] w, int k, string tag, logic with_new = 1'b0,
                           logic [27:0] nw = '0);
    exp_q.push_back(exp_byte(w, k));
    tag_q.push_back(tag);
    addr_i = 2'(k); rd_i = 1'b1;
    if (with_new) begin word_i = nw; word_vld_i = 1'b1; end
    tick();
    rd_i = 1'b0; word_vld_i = 1'b0;
  endtask

  task automatic read_word(logic [27:0] w, string tag);
    for (int k = 0; k < 4; k++) read_byte(w, k, tag);
  endtask

  // monitor: compare returned bytes in strobe cycles
  always @(negedge clk_i) begin
    if (rst_ni && rd_i) begin
      if (exp_q.size() == 0) chk("R3 unexpected read", 32'(rdata_o), 32'hx);
      else chk(tag_q.pop_front(), 32'(rdata_o), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [27:0] a, b, c, d, e;
    a = 28'hA5C3E71; b = 28'h1234567; c = 28'h9ABCDEF;
    d = 28'h0F1E2D3; e = 28'hFFFFFFF;
    tick(); tick();
    // R1
    chk("R1 avail", 32'(avail_o), 0);
    chk("R1 ovr", 32'(ovr_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    for (int k = 0; k < 4; k++) begin
      addr_i = 2'(k); #0.1;
      chk("R1 rdata", 32'(rdata_o), 0);
    end
    rst_ni = 1'b1;
    tick();
    irq_en_i = 1'b1;
    // R2, R6
    send(a);
    chk("R2 avail after load", 32'(avail_o), 1);
    chk("R6 irq pending", 32'(irq_o), 1);
    // R3 via monitor, R4 flags hold
    for (int k = 0; k < 3; k++) read_byte(a, k, "R3 word a");
    chk("R4 avail after partial read", 32'(avail_o), 1);
    // R9 idle at last address
    addr_i = 2'd3; tick(); tick();
    chk("R9 avail with no strobe", 32'(avail_o), 1);
    read_byte(a, 3, "R3 word a low");
    chk("R5 avail cleared", 32'(avail_o), 0);
    chk("R6 irq off", 32'(irq_o), 0);
    // R6 masking
    irq_en_i = 1'b0;
    send(b);
    chk("R6 masked irq", 32'(irq_o), 0);
    chk("R2 avail masked", 32'(avail_o), 1);
    irq_en_i = 1'b1; #0.1;
    chk("R6 unmask immediate", 32'(irq_o), 1);
    // R7 overrun
    send(c);
    chk("R7 ovr set", 32'(ovr_o), 1);
    read_word(c, "R7 overwritten word");
    chk("R5 ovr cleared", 32'(ovr_o), 0);
    chk("R5 avail cleared after overrun", 32'(avail_o), 0);
    // R8 coincident
    send(d);
    for (int k = 0; k < 3; k++) read_byte(d, k, "R8 word d");
    read_byte(d, 3, "R8 old low byte", 1'b1, e);
    chk("R8 avail kept", 32'(avail_o), 1);
    chk("R8 no overrun", 32'(ovr_o), 0);
    read_word(e, "R8 R3 all-ones word");
    chk("R5 final", 32'(avail_o), 0);
    tick();
    chk("R3 queue drained", 32'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule